// File: doc/BRIEF.md
# Phase-Flipping Arrival Barrier Bank

This block holds one synchronization barrier per buffer stage of a multi-stage producer/consumer pipeline. Each barrier keeps a phase bit, a programmable arrival threshold, a count of arrivals still outstanding and a count of transfer bytes still pending. Agents post arrive pulses against a stage index. A producer may post an arrive that also announces how many bytes a data mover will deliver into that stage. The data mover then reports delivered bytes against the same stage. A barrier completes when its outstanding arrivals reach zero and its pending bytes have drained. On completion its phase bit toggles and its counters re-arm for the next round.

Waiters do not poll a level flag. Each waiter holds the phase it last observed and presents it with a stage index on the query port. The query reports ready once the barrier's phase differs from the caller's phase. Each stage runs a small state machine with three states. SLOT_IDLE means the barrier is armed and untouched. SLOT_COLLECT means some arrivals have been seen but not all. SLOT_DRAIN means all arrivals are in and bytes are still pending. The transitions are: IDLE to COLLECT on a partial arrival; IDLE or COLLECT to DRAIN when the last arrival lands with bytes still pending; any state back to IDLE on completion, which flips the phase. The threshold can only be reprogrammed in SLOT_IDLE.

Top module: `phase_barrier_bank`

## Requirements
- R1: After reset every phase bit is 0, the error flag is 0, and every threshold is 1, so a single plain arrive completes a stage.
- R2: A stage completes and toggles its phase in the clock edge where its arrivals reach the programmed threshold and no bytes are pending; each later completion toggles it again.
- R3: `qry_ready` is combinationally 1 exactly when the phase of stage `qry_idx` differs from `qry_phase`, and 0 when they are equal.
- R4: An arrive with `arv_expect`=1 adds `arv_bytes` to the stage's pending byte count, and the stage cannot complete until that count is zero.
- R5: A byte report on `tx_*` subtracts `tx_bytes` from the pending count and, when arrivals are already complete, completes the stage by itself without any further arrive.
- R6: On completion the outstanding-arrival count reloads to the threshold and the pending byte count clears, so the next round again needs the full threshold of arrivals.
- R7: A byte report larger than the pending count (including any pending expectation added in the same cycle) sets the sticky `err_o`, which stays 1 until reset, and the pending count saturates at zero; if arrivals are complete the stage then completes.
- R8: An arrive and a byte report to the same stage in the same cycle are both applied before the completion test.
- R9: A `cfg_valid` write sets the threshold of stage `cfg_idx` to `cfg_count` only when that stage is in SLOT_IDLE, no arrive or byte report targets it in that cycle, and `cfg_count` is nonzero; otherwise the write has no effect.
- R10: Arrives, byte reports and configuration writes change only the stage named by their index; `phase_o` bit i is the phase of stage i.
- R11: An arrive to a stage in SLOT_DRAIN does not change its arrival count, but its byte expectation is still added to the pending count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 1 | Threshold write strobe |
| cfg_idx | input | IDX_W | Stage addressed by the threshold write |
| cfg_count | input | CNT_W | New arrival threshold |
| arv_valid | input | 1 | Arrive pulse |
| arv_idx | input | IDX_W | Stage receiving the arrive |
| arv_expect | input | 1 | Arrive also carries a byte expectation |
| arv_bytes | input | BYTE_W | Bytes expected when `arv_expect` is 1 |
| tx_valid | input | 1 | Byte-delivery report strobe |
| tx_idx | input | IDX_W | Stage receiving the byte report |
| tx_bytes | input | BYTE_W | Bytes delivered |
| qry_idx | input | IDX_W | Stage being waited on |
| qry_phase | input | 1 | Phase the caller holds |
| qry_ready | output | 1 | 1 when the wait is released |
| phase_o | output | NUM_STAGES | Current phase of every stage |
| err_o | output | 1 | Sticky byte-overflow flag |

## Verification
A stimulus on the arrive, byte or configuration inputs takes effect at the next rising edge, so `phase_o` and `err_o` are due one edge after the cycle in which it is driven. `qry_ready` follows `phase_o` and the query inputs in the same cycle with no register. The bench drives every input just after a falling edge, holds it across one rising edge, and samples at the following falling edge. Each check therefore sees exactly the one edge it expects. The vector table compares the whole phase vector after each step, which also catches a stage that changes when it should not.

// File: rtl/pbar_pkg.sv
package pbar_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE    = 2'd0,
        SLOT_COLLECT = 2'd1,
        SLOT_DRAIN   = 2'd2
    } slot_state_e;

endpackage

// File: rtl/pbar_slot.sv
module pbar_slot
    import pbar_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int BYTE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arv_hit,
    input  logic              arv_expect,
    input  logic [BYTE_W-1:0] arv_bytes,
    input  logic              tx_hit,
    input  logic [BYTE_W-1:0] tx_bytes,
    input  logic              cfg_hit,
    input  logic [CNT_W-1:0]  cfg_count,
    output logic              phase,
    output logic              ovf
);

    localparam int SUM_W = BYTE_W + 1;

    slot_state_e       state_q, state_d;
    logic [CNT_W-1:0]  thr_q;
    logic [CNT_W-1:0]  left_q;
    logic [BYTE_W-1:0] pend_q;
    logic              phase_q;

    logic [CNT_W-1:0]  left_dec;
    logic [SUM_W-1:0]  sum_bytes;
    logic [SUM_W-1:0]  sub_bytes;
    logic [SUM_W-1:0]  diff_bytes;
    logic [BYTE_W-1:0] pend_nx;
    logic              done;
    logic              cfg_take;
    logic              any_hit;

    // Datapath and outputs: counters after this cycle's events
    always_comb begin
        any_hit    = arv_hit || tx_hit;
        left_dec   = (arv_hit && (left_q != '0)) ? left_q - CNT_W'(1) : left_q;
        sum_bytes  = {1'b0, pend_q}
                   + ((arv_hit && arv_expect) ? {1'b0, arv_bytes} : '0);
        sub_bytes  = tx_hit ? {1'b0, tx_bytes} : '0;
        ovf        = tx_hit && (sub_bytes > sum_bytes);
        diff_bytes = sum_bytes - sub_bytes;
        pend_nx    = ovf ? '0 : diff_bytes[BYTE_W-1:0];
        done       = any_hit && (left_dec == '0) && (pend_nx == '0);
        cfg_take   = cfg_hit && (state_q == SLOT_IDLE) && !any_hit
                   && (cfg_count != '0);
        phase      = phase_q;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: begin
                if (done)                     state_d = SLOT_IDLE;
                else if (left_dec == '0)      state_d = SLOT_DRAIN;
                else if (left_dec != left_q)  state_d = SLOT_COLLECT;
                else                          state_d = SLOT_IDLE;
            end
            SLOT_COLLECT: begin
                if (done)                     state_d = SLOT_IDLE;
                else if (left_dec == '0)      state_d = SLOT_DRAIN;
                else                          state_d = SLOT_COLLECT;
            end
            SLOT_DRAIN: begin
                if (done)                     state_d = SLOT_IDLE;
                else                          state_d = SLOT_DRAIN;
            end
            default:                          state_d = SLOT_IDLE;
        endcase
    end

    // State register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            thr_q   <= CNT_W'(1);
            left_q  <= CNT_W'(1);
            pend_q  <= '0;
            phase_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (done) begin
                phase_q <= ~phase_q;
                left_q  <= thr_q;
                pend_q  <= '0;
            end else if (cfg_take) begin
                thr_q   <= cfg_count;
                left_q  <= cfg_count;
            end else begin
                left_q  <= left_dec;
                pend_q  <= pend_nx;
            end
        end
    end

endmodule

// File: rtl/pbar_query.sv
module pbar_query #(
    parameter int NUM_STAGES = 4,
    parameter int IDX_W      = 2
) (
    input  logic [NUM_STAGES-1:0] phase_vec,
    input  logic [IDX_W-1:0]      qry_idx,
    input  logic                  qry_phase,
    output logic                  qry_ready
);

    always_comb begin
        qry_ready = 1'b0;
        for (int i = 0; i < NUM_STAGES; i++) begin
            if (qry_idx == IDX_W'(i)) qry_ready = (phase_vec[i] != qry_phase);
        end
    end

endmodule

// File: rtl/phase_barrier_bank.sv
module phase_barrier_bank #(
    parameter int NUM_STAGES = 4,
    parameter int CNT_W      = 8,
    parameter int BYTE_W     = 16,
    localparam int IDX_W     = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_valid,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic [CNT_W-1:0]      cfg_count,
    input  logic                  arv_valid,
    input  logic [IDX_W-1:0]      arv_idx,
    input  logic                  arv_expect,
    input  logic [BYTE_W-1:0]     arv_bytes,
    input  logic                  tx_valid,
    input  logic [IDX_W-1:0]      tx_idx,
    input  logic [BYTE_W-1:0]     tx_bytes,
    input  logic [IDX_W-1:0]      qry_idx,
    input  logic                  qry_phase,
    output logic                  qry_ready,
    output logic [NUM_STAGES-1:0] phase_o,
    output logic                  err_o
);

    logic [NUM_STAGES-1:0] ovf_vec;
    logic                  err_q;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_slot
        pbar_slot #(
            .CNT_W  (CNT_W),
            .BYTE_W (BYTE_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .arv_hit    (arv_valid && (arv_idx == IDX_W'(g))),
            .arv_expect (arv_expect),
            .arv_bytes  (arv_bytes),
            .tx_hit     (tx_valid && (tx_idx == IDX_W'(g))),
            .tx_bytes   (tx_bytes),
            .cfg_hit    (cfg_valid && (cfg_idx == IDX_W'(g))),
            .cfg_count  (cfg_count),
            .phase      (phase_o[g]),
            .ovf        (ovf_vec[g])
        );
    end

    pbar_query #(
        .NUM_STAGES (NUM_STAGES),
        .IDX_W      (IDX_W)
    ) u_query (
        .phase_vec (phase_o),
        .qry_idx   (qry_idx),
        .qry_phase (qry_phase),
        .qry_ready (qry_ready)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else if (|ovf_vec) err_q <= 1'b1;
    end

    assign err_o = err_q;

endmodule

// File: rtl/pbar_checker.sv
module pbar_checker #(
    parameter int NUM_STAGES = 4,
    parameter int IDX_W      = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  arv_valid,
    input logic [IDX_W-1:0]      arv_idx,
    input logic                  tx_valid,
    input logic [IDX_W-1:0]      tx_idx,
    input logic [IDX_W-1:0]      qry_idx,
    input logic                  qry_phase,
    input logic                  qry_ready,
    input logic [NUM_STAGES-1:0] phase_o,
    input logic                  err_o
);

    AST_RESET_PHASE: assert property (@(posedge clk) !rst_n |=> (phase_o == '0) && !err_o); // R1

    AST_QUERY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(qry_idx) < NUM_STAGES) |-> (qry_ready == (phase_o[qry_idx] != qry_phase))); // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err_o |=> err_o); // R7

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |=> ($stable(err_o) || !$past(rst_n))); // R7

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_chk
        AST_UNTOUCHED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            !(arv_valid && (arv_idx == IDX_W'(g))) && !(tx_valid && (tx_idx == IDX_W'(g)))
            |=> $stable(phase_o[g])); // R10
    end

endmodule

bind phase_barrier_bank pbar_checker #(
    .NUM_STAGES (NUM_STAGES),
    .IDX_W      (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arv_valid (arv_valid),
    .arv_idx   (arv_idx),
    .tx_valid  (tx_valid),
    .tx_idx    (tx_idx),
    .qry_idx   (qry_idx),
    .qry_phase (qry_phase),
    .qry_ready (qry_ready),
    .phase_o   (phase_o),
    .err_o     (err_o)
);

// File: tb/phase_barrier_bank_tb.sv
module phase_barrier_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int CW = 8;
    localparam int BW = 16;
    localparam int IW = 2;
    localparam int NVEC = 10;

    typedef struct packed {
        logic          av;
        logic [IW-1:0] ai;
        logic          ae;
        logic [BW-1:0] ab;
        logic          tv;
        logic [IW-1:0] ti;
        logic [BW-1:0] tb;
        logic [N-1:0]  ph;
    } vec_t;

    // arrive fields | byte-report fields | expected phase vector
    localparam logic [42:0] TBL [0:NVEC-1] = '{
        {1'b1, 2'd0, 1'b0, 16'd0,  1'b0, 2'd0, 16'd0,  4'b0001}, // R2 stage0 plain arrive
        {1'b1, 2'd1, 1'b1, 16'd64, 1'b0, 2'd0, 16'd0,  4'b0001}, // R4 expect 64
        {1'b0, 2'd0, 1'b0, 16'd0,  1'b1, 2'd1, 16'd32, 4'b0001}, // R4 half delivered
        {1'b0, 2'd0, 1'b0, 16'd0,  1'b1, 2'd1, 16'd32, 4'b0011}, // R5 bytes alone complete
        {1'b1, 2'd2, 1'b1, 16'd10, 1'b1, 2'd2, 16'd10, 4'b0111}, // R8 same cycle
        {1'b1, 2'd0, 1'b0, 16'd0,  1'b0, 2'd0, 16'd0,  4'b0110}, // R2 toggle back
        {1'b1, 2'd3, 1'b1, 16'd8,  1'b0, 2'd0, 16'd0,  4'b0110}, // R4
        {1'b0, 2'd0, 1'b0, 16'd0,  1'b1, 2'd3, 16'd5,  4'b0110}, // R4 partial
        {1'b0, 2'd0, 1'b0, 16'd0,  1'b1, 2'd3, 16'd3,  4'b1110}, // R5
        {1'b0, 2'd0, 1'b0, 16'd0,  1'b0, 2'd0, 16'd0,  4'b1110}  // R10 quiet cycle
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          arv_valid = 1'b0;
    logic [IW-1:0] arv_idx = '0;
    logic          arv_expect = 1'b0;
    logic [BW-1:0] arv_bytes = '0;
    logic          tx_valid = 1'b0;
    logic [IW-1:0] tx_idx = '0;
    logic [BW-1:0] tx_bytes = '0;
    logic [IW-1:0] qry_idx = '0;
    logic          qry_phase = 1'b0;
    logic          qry_ready;
    logic [N-1:0]  phase_o;
    logic          err_o;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_barrier_bank #(.NUM_STAGES(N), .CNT_W(CW), .BYTE_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_idx(cfg_idx), .cfg_count(cfg_count),
        .arv_valid(arv_valid), .arv_idx(arv_idx), .arv_expect(arv_expect), .arv_bytes(arv_bytes),
        .tx_valid(tx_valid), .tx_idx(tx_idx), .tx_bytes(tx_bytes),
        .qry_idx(qry_idx), .qry_phase(qry_phase), .qry_ready(qry_ready),
        .phase_o(phase_o), .err_o(err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus from a falling edge; return at the next falling edge.
    task automatic step(input logic av, input logic [IW-1:0] ai, input logic ae,
                        input logic [BW-1:0] ab, input logic tv, input logic [IW-1:0] ti,
                        input logic [BW-1:0] tb, input logic cv, input logic [CW-1:0] cc,
                        input logic [IW-1:0] ci);
        arv_valid = av; arv_idx = ai; arv_expect = ae; arv_bytes = ab;
        tx_valid = tv;  tx_idx = ti;  tx_bytes = tb;
        cfg_valid = cv; cfg_count = cc; cfg_idx = ci;
        @(negedge clk);
        arv_valid = 1'b0; tx_valid = 1'b0; cfg_valid = 1'b0;
    endtask

    task automatic arrive(input logic [IW-1:0] s);
        step(1'b1, s, 1'b0, '0, 1'b0, '0, '0, 1'b0, '0, '0);
    endtask

    task automatic cfg(input logic [IW-1:0] s, input logic [CW-1:0] c);
        step(1'b0, '0, 1'b0, '0, 1'b0, '0, '0, 1'b1, c, s);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state, also R3 query against it
        chk("R1 phase", 32'(phase_o), 32'h0);
        chk("R1 err", 32'(err_o), 32'h0);
        qry_idx = 2'd2; qry_phase = 1'b0; #1;
        chk("R3 equal phase blocks", 32'(qry_ready), 32'h0);
        qry_phase = 1'b1; #1;
        chk("R3 differing phase ready", 32'(qry_ready), 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 phase after release", 32'(phase_o), 32'h0);

        for (int k = 0; k < NVEC; k++) begin
            vec_t v;
            v = vec_t'(TBL[k]);
            step(v.av, v.ai, v.ae, v.ab, v.tv, v.ti, v.tb, 1'b0, '0, '0);
            chk($sformatf("R2/R4/R5/R8/R10 vector %0d", k), 32'(phase_o), 32'(v.ph));
            chk($sformatf("R7 no error vector %0d", k), 32'(err_o), 32'h0);
        end

        qry_idx = 2'd3; qry_phase = 1'b1; #1;
        chk("R3 stage3 caller phase 1", 32'(qry_ready), 32'h0);
        qry_phase = 1'b0; #1;
        chk("R3 stage3 caller phase 0", 32'(qry_ready), 32'h1);

        // R9 threshold 3 on stage 0 (phase 0, idle)
        cfg(2'd0, 8'd3);
        arrive(2'd0); arrive(2'd0);
        chk("R9 two of three arrivals", 32'(phase_o[0]), 32'h0);
        cfg(2'd0, 8'd1); // ignored: stage busy
        arrive(2'd0);
        chk("R9 busy write ignored, third completes", 32'(phase_o[0]), 32'h1);
        // R6 re-arm needs full threshold again
        arrive(2'd0);
        chk("R6 reloaded threshold", 32'(phase_o[0]), 32'h1);
        arrive(2'd0); arrive(2'd0);
        chk("R6 second round completes", 32'(phase_o[0]), 32'h0);
        cfg(2'd0, 8'd0); // ignored: zero
        arrive(2'd0);
        chk("R9 zero write ignored", 32'(phase_o[0]), 32'h0);
        arrive(2'd0); arrive(2'd0);
        chk("R9 threshold still three", 32'(phase_o[0]), 32'h1);

        // R11 extra arrive in drain on stage 1 (phase 1)
        step(1'b1, 2'd1, 1'b1, 16'd4, 1'b0, '0, '0, 1'b0, '0, '0);
        step(1'b1, 2'd1, 1'b1, 16'd4, 1'b0, '0, '0, 1'b0, '0, '0);
        step(1'b0, '0, 1'b0, '0, 1'b1, 2'd1, 16'd4, 1'b0, '0, '0);
        chk("R11 extra expectation still pending", 32'(phase_o[1]), 32'h1);
        step(1'b0, '0, 1'b0, '0, 1'b1, 2'd1, 16'd4, 1'b0, '0, '0);
        chk("R11 drained", 32'(phase_o[1]), 32'h0);

        // R7 overflow on stage 2 (phase 1)
        chk("R7 clean before overflow", 32'(err_o), 32'h0);
        step(1'b1, 2'd2, 1'b1, 16'd4, 1'b0, '0, '0, 1'b0, '0, '0);
        step(1'b0, '0, 1'b0, '0, 1'b1, 2'd2, 16'd6, 1'b0, '0, '0);
        chk("R7 error raised", 32'(err_o), 32'h1);
        chk("R7 saturated count completes", 32'(phase_o[2]), 32'h0);
        @(negedge clk);
        chk("R7 error sticky", 32'(err_o), 32'h1);
        chk("R10 final phase vector", 32'(phase_o), 32'h9);

        ended = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule